// File: doc/BRIEF.md
# Integer ALU with Shifter

This block is the integer execution datapath of a load/store RISC pipeline. It accepts two 32-bit operands, a 5-bit immediate shift count and a 5-bit operation code. In the same cycle it returns a 32-bit result and a flag that asks the core to trap on signed overflow. The block is purely combinational, so the surrounding stage registers its inputs and outputs.

The surrounding logic handles immediate forms before the block sees them. For arithmetic and compares it presents a sign-extended immediate on operand B. For AND, OR and XOR it presents a zero-extended immediate on operand B. For load-upper-immediate it places the 16-bit constant in operand B bits 15..0.

Add, subtract and both compares share one carry chain. The three shift kinds share one barrel shifter, which takes its count either from the immediate count pin or from the low 5 bits of operand A.

Top module: `alu_core`

## Requirements
- R1: Code 0 (trapping add) gives A+B modulo 2^32 and raises the overflow flag exactly when the true signed sum lies outside the 32-bit two's-complement range.
- R2: Code 2 (trapping subtract) gives A−B modulo 2^32 and raises the overflow flag exactly when the true signed difference lies outside the 32-bit two's-complement range.
- R3: Code 1 (wrapping add) and code 3 (wrapping subtract) give the same result as codes 0 and 2 and never raise the overflow flag.
- R4: Code 4 gives A AND B, code 5 gives A OR B, and code 6 gives A XOR B, bit by bit.
- R5: Code 7 gives the bitwise complement of (A OR B).
- R6: Code 14 gives 1 when A is less than B as a signed number, and 0 otherwise. Bits 31..1 are always 0.
- R7: Code 15 gives 1 when A is less than B as an unsigned number, and 0 otherwise. Bits 31..1 are always 0.
- R8: Codes 8, 9 and 10 shift B by the immediate count pin. Code 8 shifts left and fills with zeros. Code 9 shifts right and fills with zeros. Code 10 shifts right and fills with copies of B bit 31.
- R9: Codes 11, 12 and 13 perform the same left, logical-right and arithmetic-right shifts of B, taking the count from A bits 4..0. A bits 31..5 and the immediate count pin have no effect.
- R10: Code 16 gives B bits 15..0 in result bits 31..16 and zeros in bits 15..0. B bits 31..16 have no effect.
- R11: The overflow flag is 0 for every code other than 0 and 2. Codes 17 to 31 give a result of 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 5 | Operation code |
| opnd_a | input | 32 | First operand; also supplies the count for variable shifts |
| opnd_b | input | 32 | Second operand; the value shifted, and the upper-immediate source |
| shamt_imm | input | 5 | Immediate shift count |
| result | output | 32 | Operation result |
| ovf_trap | output | 1 | Signed overflow on a trapping add or subtract |

## Verification
Add and subtract are tried at each sign boundary: the largest positive plus one, the most negative minus one, the most negative plus itself, and zero minus the most negative. These cases separate a correct overflow rule from one that only looks at carries, and they show that the wrapping codes keep the sum while dropping the flag. Compares use operand pairs that are ordered one way as signed and the other way as unsigned, which catches a swapped or shared compare. Shifts use a negative operand with counts of 0, 4 and 31, and a count register whose upper bits are set, which exposes wrong fill or a wrong count source. A pseudo-random sweep over every code then confirms the opcode decode, including codes 17 to 31.

// File: rtl/alu_pkg.sv
// Package: shared operation codes and shift kinds for the integer ALU.
// Assumes a 5-bit operation code; codes not listed here are treated as unused.
package alu_pkg;

    typedef enum logic [4:0] {
        OP_ADD_TRAP = 5'd0,
        OP_ADD_WRAP = 5'd1,
        OP_SUB_TRAP = 5'd2,
        OP_SUB_WRAP = 5'd3,
        OP_AND      = 5'd4,
        OP_OR       = 5'd5,
        OP_XOR      = 5'd6,
        OP_NOR      = 5'd7,
        OP_SHL_I    = 5'd8,
        OP_SHR_I    = 5'd9,
        OP_SAR_I    = 5'd10,
        OP_SHL_V    = 5'd11,
        OP_SHR_V    = 5'd12,
        OP_SAR_V    = 5'd13,
        OP_LT_S     = 5'd14,
        OP_LT_U     = 5'd15,
        OP_UPPER    = 5'd16
    } alu_op_e;

    typedef enum logic [1:0] {
        SHK_LEFT  = 2'd0,
        SHK_RLOG  = 2'd1,
        SHK_RARI  = 2'd2
    } shift_kind_e;

    typedef enum logic [1:0] {
        LG_AND = 2'd0,
        LG_OR  = 2'd1,
        LG_XOR = 2'd2,
        LG_NOR = 2'd3
    } logic_fn_e;

endpackage

// File: rtl/alu_addsub.sv
// Module: shared adder/subtractor.
// Computes A+B or A-B (as A + ~B + 1) on one carry chain.
// Returns the sum, the carry out, and the raw signed-overflow condition.
// Assumes nothing about the operation; the caller decides whether overflow matters.
module alu_addsub #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             sub,
    output logic [WIDTH-1:0] sum,
    output logic             carry,
    output logic             ovf
);

    logic [WIDTH-1:0] b_eff;
    logic [WIDTH:0]   full;

    // Invert B for subtraction and form the widened sum with carry-in.
    always_comb begin
        b_eff = sub ? ~b : b;
        full  = {1'b0, a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, sub};
    end

    // Split the widened sum; overflow when equal-signed inputs give a differing sign.
    always_comb begin
        sum   = full[WIDTH-1:0];
        carry = full[WIDTH];
        ovf   = (a[WIDTH-1] == b_eff[WIDTH-1]) && (sum[WIDTH-1] != a[WIDTH-1]);
    end

endmodule

// File: rtl/alu_logic.sv
// Module: bitwise logic unit (AND, OR, XOR, NOR).
// Assumes the immediate forms arrive already zero-extended on B.
module alu_logic #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0]  a,
    input  logic [WIDTH-1:0]  b,
    input  alu_pkg::logic_fn_e fn,
    output logic [WIDTH-1:0]  y
);
    import alu_pkg::*;

    // Select one bitwise function.
    always_comb begin
        unique case (fn)
            LG_AND:  y = a & b;
            LG_OR:   y = a | b;
            LG_XOR:  y = a ^ b;
            default: y = ~(a | b);
        endcase
    end

endmodule

// File: rtl/alu_shifter.sv
// Module: logarithmic barrel shifter.
// Handles left, logical-right and arithmetic-right shifts.
// A left shift is done as a right shift of the bit-reversed input, with the output reversed back.
// Assumes WIDTH is a power of two.
module alu_shifter #(
    parameter int WIDTH = 32,
    parameter int CNT_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0]    din,
    input  logic [CNT_W-1:0]    cnt,
    input  alu_pkg::shift_kind_e kind,
    output logic [WIDTH-1:0]    dout
);
    import alu_pkg::*;

    localparam int STAGES = CNT_W;

    logic [WIDTH-1:0]             rev_in;
    logic [WIDTH-1:0]             pre;
    logic                         fill;
    logic [STAGES:0][WIDTH-1:0]   stg;
    logic [WIDTH-1:0]             rev_out;

    // Bit-reverse the input and the last stage for the left-shift path.
    for (genvar i = 0; i < WIDTH; i++) begin : g_rev
        assign rev_in[i]  = din[WIDTH-1-i];
        assign rev_out[i] = stg[STAGES][WIDTH-1-i];
    end

    // Choose the stage-0 input and the fill bit by shift kind.
    always_comb begin
        pre  = (kind == SHK_LEFT) ? rev_in : din;
        fill = (kind == SHK_RARI) && din[WIDTH-1];
    end

    assign stg[0] = pre;

    // Stage k moves the data right by 2**k when count bit k is set.
    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        localparam int STEP = 1 << k;
        assign stg[k+1] = cnt[k] ? {{STEP{fill}}, stg[k][WIDTH-1:STEP]} : stg[k];
    end

    // Undo the reversal for left shifts.
    always_comb begin
        dout = (kind == SHK_LEFT) ? rev_out : stg[STAGES];
    end

endmodule

// File: rtl/alu_core.sv
// Module: integer execution unit (top).
// Decodes the operation code and steers the operands to the shared adder, logic unit and shifter.
// It then selects the result.
// Fully combinational. The overflow flag is meaningful only for trapping add and subtract,
// and is held low otherwise. Codes 17..31 give zero.
module alu_core #(
    parameter int WIDTH = 32,
    parameter int CNT_W = $clog2(WIDTH)
) (
    input  logic [4:0]       op_sel,
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    input  logic [CNT_W-1:0] shamt_imm,
    output logic [WIDTH-1:0] result,
    output logic             ovf_trap
);
    import alu_pkg::*;

    localparam int HALF = WIDTH / 2;

    alu_op_e          op;
    logic             use_sub;
    logic             var_shift;
    logic [CNT_W-1:0] sh_cnt;
    shift_kind_e      sh_kind;
    logic_fn_e        lg_fn;
    logic [WIDTH-1:0] as_sum;
    logic             as_carry;
    logic             as_ovf;
    logic [WIDTH-1:0] lg_y;
    logic [WIDTH-1:0] sh_y;
    logic             lt_signed;
    logic             lt_unsigned;

    assign op = alu_op_e'(op_sel);

    // Decode the adder direction and the shift count source.
    always_comb begin
        use_sub   = (op == OP_SUB_TRAP) || (op == OP_SUB_WRAP) ||
                    (op == OP_LT_S)     || (op == OP_LT_U);
        var_shift = (op == OP_SHL_V) || (op == OP_SHR_V) || (op == OP_SAR_V);
        sh_cnt    = var_shift ? opnd_a[CNT_W-1:0] : shamt_imm;
    end

    // Decode the shift kind and the logic function.
    always_comb begin
        unique case (op)
            OP_SHR_I, OP_SHR_V: sh_kind = SHK_RLOG;
            OP_SAR_I, OP_SAR_V: sh_kind = SHK_RARI;
            default:            sh_kind = SHK_LEFT;
        endcase
        unique case (op)
            OP_OR:   lg_fn = LG_OR;
            OP_XOR:  lg_fn = LG_XOR;
            OP_NOR:  lg_fn = LG_NOR;
            default: lg_fn = LG_AND;
        endcase
    end

    alu_addsub #(.WIDTH(WIDTH)) u_addsub (
        .a     (opnd_a),
        .b     (opnd_b),
        .sub   (use_sub),
        .sum   (as_sum),
        .carry (as_carry),
        .ovf   (as_ovf)
    );

    alu_logic #(.WIDTH(WIDTH)) u_logic (
        .a  (opnd_a),
        .b  (opnd_b),
        .fn (lg_fn),
        .y  (lg_y)
    );

    alu_shifter #(.WIDTH(WIDTH), .CNT_W(CNT_W)) u_shift (
        .din  (opnd_b),
        .cnt  (sh_cnt),
        .kind (sh_kind),
        .dout (sh_y)
    );

    // Derive the compares from the subtractor: signed uses sign XOR overflow, unsigned uses borrow.
    always_comb begin
        lt_signed   = as_sum[WIDTH-1] ^ as_ovf;
        lt_unsigned = ~as_carry;
    end

    // Select the result by operation.
    always_comb begin
        unique case (op)
            OP_ADD_TRAP, OP_ADD_WRAP,
            OP_SUB_TRAP, OP_SUB_WRAP:         result = as_sum;
            OP_AND, OP_OR, OP_XOR, OP_NOR:    result = lg_y;
            OP_SHL_I, OP_SHR_I, OP_SAR_I,
            OP_SHL_V, OP_SHR_V, OP_SAR_V:     result = sh_y;
            OP_LT_S:   result = {{(WIDTH-1){1'b0}}, lt_signed};
            OP_LT_U:   result = {{(WIDTH-1){1'b0}}, lt_unsigned};
            OP_UPPER:  result = {opnd_b[HALF-1:0], {HALF{1'b0}}};
            default:   result = '0;
        endcase
    end

    // Raise the trap flag only for the trapping add and subtract.
    always_comb begin
        ovf_trap = ((op == OP_ADD_TRAP) || (op == OP_SUB_TRAP)) && as_ovf;
    end

endmodule

// File: rtl/alu_core_chk.sv
// Module: property checker for alu_core, attached by bind.
// The block has no clock, so the checks are immediate assertions on settled values.
module alu_core_chk #(
    parameter int WIDTH = 32,
    parameter int CNT_W = $clog2(WIDTH)
) (
    input logic [4:0]       op_sel,
    input logic [WIDTH-1:0] opnd_a,
    input logic [WIDTH-1:0] opnd_b,
    input logic [CNT_W-1:0] shamt_imm,
    input logic [WIDTH-1:0] result,
    input logic             ovf_trap
);
    localparam int HALF = WIDTH / 2;

    // Relate operation, operands and outputs whenever any of them changes.
    always_comb begin
        // R1
        add_ovf_sign_chk: assert (!(op_sel == 5'd0 && ovf_trap) ||
            (opnd_a[WIDTH-1] == opnd_b[WIDTH-1] && result[WIDTH-1] != opnd_a[WIDTH-1]));
        // R2
        sub_ovf_sign_chk: assert (!(op_sel == 5'd2 && ovf_trap) ||
            (opnd_a[WIDTH-1] != opnd_b[WIDTH-1] && result[WIDTH-1] != opnd_a[WIDTH-1]));
        // R3
        wrap_no_ovf_chk: assert (!((op_sel == 5'd1 || op_sel == 5'd3) && ovf_trap));
        // R5
        nor_disjoint_chk: assert (op_sel != 5'd7 ||
            ((result & (opnd_a | opnd_b)) == '0 && (result | opnd_a | opnd_b) == '1));
        // R6
        lt_signed_bool_chk: assert (op_sel != 5'd14 || result[WIDTH-1:1] == '0);
        // R7
        lt_unsigned_bool_chk: assert (op_sel != 5'd15 || result[WIDTH-1:1] == '0);
        // R8
        sar_sign_keep_chk: assert (op_sel != 5'd10 || result[WIDTH-1] == opnd_b[WIDTH-1]);
        // R10
        upper_place_chk: assert (op_sel != 5'd16 ||
            (result[HALF-1:0] == '0 && result[WIDTH-1:HALF] == opnd_b[HALF-1:0]));
        // R11
        other_no_ovf_chk: assert (op_sel == 5'd0 || op_sel == 5'd2 || !ovf_trap);
        // R11
        unused_zero_chk: assert (op_sel < 5'd17 || result == '0);
    end

endmodule

bind alu_core alu_core_chk #(.WIDTH(WIDTH), .CNT_W(CNT_W)) u_chk (
    .op_sel    (op_sel),
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .shamt_imm (shamt_imm),
    .result    (result),
    .ovf_trap  (ovf_trap)
);

// File: tb/alu_core_test.sv
// Bench: scoreboard for alu_core.
// A driver task applies each operation at the falling edge and queues the expected item.
// A monitor compares it at the next rising edge.
module alu_core_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  op_sel = '0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic [4:0]  shamt_imm = '0;
    logic [31:0] result;
    logic        ovf_trap;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    logic [32:0] q_exp[$];
    string       q_tag[$];

    always #2.5 clk = ~clk;

    alu_core uut (
        .op_sel    (op_sel),
        .opnd_a    (opnd_a),
        .opnd_b    (opnd_b),
        .shamt_imm (shamt_imm),
        .result    (result),
        .ovf_trap  (ovf_trap)
    );

    // Reference model written from the requirements.
    function automatic logic [32:0] model(input logic [4:0] op, input logic [31:0] a,
                                          input logic [31:0] b, input logic [4:0] sh);
        logic [32:0] wide;
        logic [31:0] r;
        logic        o;
        r = '0;
        o = 1'b0;
        case (op)
            5'd0, 5'd1: begin
                wide = {a[31], a} + {b[31], b};
                r = wide[31:0];
                o = (op == 5'd0) && (wide[32] != wide[31]);
            end
            5'd2, 5'd3: begin
                wide = {a[31], a} - {b[31], b};
                r = wide[31:0];
                o = (op == 5'd2) && (wide[32] != wide[31]);
            end
            5'd4:  r = a & b;
            5'd5:  r = a | b;
            5'd6:  r = a ^ b;
            5'd7:  r = ~(a | b);
            5'd8:  r = b << sh;
            5'd9:  r = b >> sh;
            5'd10: r = $signed(b) >>> sh;
            5'd11: r = b << a[4:0];
            5'd12: r = b >> a[4:0];
            5'd13: r = $signed(b) >>> a[4:0];
            5'd14: r = {31'd0, $signed(a) < $signed(b)};
            5'd15: r = {31'd0, a < b};
            5'd16: r = {b[15:0], 16'h0000};
            default: r = '0;
        endcase
        return {o, r};
    endfunction

    // Requirement tag for an operation code.
    function automatic string tag_of(input logic [4:0] op);
        case (op)
            5'd0: return "R1";
            5'd2: return "R2";
            5'd1, 5'd3: return "R3";
            5'd4, 5'd5, 5'd6: return "R4";
            5'd7: return "R5";
            5'd8, 5'd9, 5'd10: return "R8";
            5'd11, 5'd12, 5'd13: return "R9";
            5'd14: return "R6";
            5'd15: return "R7";
            5'd16: return "R10";
            default: return "R11";
        endcase
    endfunction

    // Driver: apply one operation and queue its expected output.
    task automatic drive(input logic [4:0] op, input logic [31:0] a, input logic [31:0] b,
                         input logic [4:0] sh, input string tag);
        @(negedge clk);
        op_sel    = op;
        opnd_a    = a;
        opnd_b    = b;
        shamt_imm = sh;
        q_exp.push_back(model(op, a, b, sh));
        q_tag.push_back(tag);
    endtask

    // Monitor: compare queued expectations against the outputs at the rising edge.
    always @(posedge clk) begin
        if (rst_n && q_exp.size() > 0) begin
            logic [32:0] e;
            string t;
            e = q_exp.pop_front();
            t = q_tag.pop_front();
            checks++;
            if ({ovf_trap, result} !== e) begin
                fails++;
                $display("FAIL %s op=%0d a=%h b=%h sh=%0d: got ovf=%b res=%h, expected ovf=%b res=%h",
                         t, op_sel, opnd_a, opnd_b, shamt_imm, ovf_trap, result, e[32], e[31:0]);
            end
        end
    end

    // Watchdog: end a hung run as a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog expired after %0d cycles", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] lfsr;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // Reset state: idle inputs give zero and no flag.
        drive(5'd0, 32'h0, 32'h0, 5'd0, "R1 reset");
        // R1 trapping add
        drive(5'd0, 32'd5, 32'd7, 5'd0, "R1");
        drive(5'd0, 32'h7fffffff, 32'h1, 5'd0, "R1");
        drive(5'd0, 32'h80000000, 32'h80000000, 5'd0, "R1");
        drive(5'd0, 32'hffffffff, 32'h1, 5'd0, "R1");
        // R2 trapping subtract
        drive(5'd2, 32'd10, 32'd3, 5'd0, "R2");
        drive(5'd2, 32'h80000000, 32'h1, 5'd0, "R2");
        drive(5'd2, 32'h7fffffff, 32'hffffffff, 5'd0, "R2");
        drive(5'd2, 32'h0, 32'h80000000, 5'd0, "R2");
        drive(5'd2, 32'hffffffff, 32'h7fffffff, 5'd0, "R2");
        // R3 wrapping forms keep the result, never flag
        drive(5'd1, 32'h7fffffff, 32'h1, 5'd0, "R3");
        drive(5'd3, 32'h80000000, 32'h1, 5'd0, "R3");
        // R4 bitwise logic
        drive(5'd4, 32'hf0f0ff00, 32'h0ff0f0f0, 5'd0, "R4");
        drive(5'd5, 32'hf0f0ff00, 32'h0ff0f0f0, 5'd0, "R4");
        drive(5'd6, 32'hf0f0ff00, 32'h0ff0f0f0, 5'd0, "R4");
        // R5 nor
        drive(5'd7, 32'hf0f0ff00, 32'h0ff0f0f0, 5'd0, "R5");
        // R6 signed compare
        drive(5'd14, 32'hffffffff, 32'h1, 5'd0, "R6");
        drive(5'd14, 32'h1, 32'hffffffff, 5'd0, "R6");
        drive(5'd14, 32'h80000000, 32'h7fffffff, 5'd0, "R6");
        drive(5'd14, 32'h1234, 32'h1234, 5'd0, "R6");
        // R7 unsigned compare
        drive(5'd15, 32'h1, 32'hffffffff, 5'd0, "R7");
        drive(5'd15, 32'hffffffff, 32'h1, 5'd0, "R7");
        drive(5'd15, 32'h5, 32'h5, 5'd0, "R7");
        // R8 immediate shifts; A has set low bits that must not matter
        drive(5'd8, 32'h0000001f, 32'h8000000f, 5'd4, "R8");
        drive(5'd9, 32'h0000001f, 32'h80000000, 5'd31, "R8");
        drive(5'd10, 32'h0000001f, 32'h80000000, 5'd4, "R8");
        drive(5'd10, 32'h0, 32'h80000000, 5'd31, "R8");
        drive(5'd10, 32'h0, 32'h40000000, 5'd4, "R8");
        drive(5'd10, 32'h0, 32'hdeadbeef, 5'd0, "R8");
        // R9 variable shifts; upper A bits and immediate count ignored
        drive(5'd11, 32'hffffffe3, 32'h00000001, 5'd17, "R9");
        drive(5'd12, 32'h00000020, 32'h80000000, 5'd9, "R9");
        drive(5'd13, 32'hfffffe08, 32'h80000000, 5'd1, "R9");
        // R10 upper immediate; B upper half ignored
        drive(5'd16, 32'hffffffff, 32'habcd1234, 5'd3, "R10");
        // R11 unused codes and no flag on other ops
        drive(5'd17, 32'h7fffffff, 32'h1, 5'd7, "R11");
        drive(5'd31, 32'hffffffff, 32'hffffffff, 5'd31, "R11");
        drive(5'd4, 32'h7fffffff, 32'h1, 5'd0, "R11");
        drive(5'd14, 32'h80000000, 32'h1, 5'd0, "R11");
        // Sweep: every code with pseudo-random operands
        lfsr = 32'hace1_2468;
        for (int i = 0; i < 320; i++) begin
            logic [31:0] va;
            logic [31:0] vb;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            va = lfsr;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            vb = lfsr ^ {lfsr[15:0], lfsr[31:16]};
            drive(5'(i % 32), va, vb, lfsr[4:0], tag_of(5'(i % 32)));
        end
        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule